// File: doc/BRIEF.md
# Switch Propagated Time Clock

This block holds the local time value that a switch uses to timestamp traffic on its downstream ports. The upstream requester logic finishes a time exchange and presents one result: the master time it received, the measured link delay, and the local send and receive instants of its request (T1) and of the reply (T4). On that pulse the clock is overwritten with master time minus link delay plus the request-to-reply interval (T4 − T1), plus a fixed load-latency constant. After the load the clock simply adds a fixed granularity on every core cycle.

Because a local oscillator drifts away from the master, the clock is only trusted for a bounded window after each load. A cycle counter marks the clock invalid when that window passes without a fresh load, unless a phase-locked input says no drift can occur. In root mode the switch is itself the time source: upstream results are ignored, the clock free-runs and is always reported valid.

The control is a four-state machine. `ST_INVALID` (no trusted time) goes to `ST_TRACKING` on an accepted load, or to `ST_PINNED` if phase lock is asserted at that load. `ST_TRACKING` restarts its window on a load, moves to `ST_PINNED` when phase lock is asserted, and falls back to `ST_INVALID` when the window expires. `ST_PINNED` returns to `ST_TRACKING` when phase lock drops, with the window count resuming where it stopped. Any state moves to `ST_ROOT` while root mode is set; `ST_ROOT` leaves to `ST_INVALID` when root mode clears, or straight to `ST_TRACKING`/`ST_PINNED` if a load arrives in that same cycle.

Top module: `swclk_top`

## Requirements
- R1: While reset is held, the time output is 0 and the valid output is 0 (with root mode low).
- R2: In every cycle without an accepted load, the time output grows by exactly GRAN (default 5) from one cycle to the next, modulo 2^64; this also holds while the clock is invalid and in root mode.
- R3: When res_valid_i is high at a clock edge and root mode is low, the time output after that edge equals res_master_i − res_link_dly_i + (res_t4_i − res_t1_i) + load_lat_i, computed modulo 2^64.
- R4: Outside root mode the valid output stays low from reset until the first accepted load, and rises in the cycle after that load.
- R5: After a load with phase lock low, the valid output stays high for exactly TIMEOUT_CYC cycles (edges) and drops at the TIMEOUT_CYC-th edge with no further load.
- R6: A load restarts the window in its own cycle, including a load that arrives at the very edge where the window would expire.
- R7: While phase_lock_i is high the valid output never drops because of the window, however long no load arrives.
- R8: While root_mode_i is high, the valid output is high in the same cycle and results on res_valid_i do not change the time output.
- R9: When root_mode_i clears with no load, the valid output is low in that same cycle and stays low until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_mode_i | input | 1 | Switch is the time source; ignore upstream results |
| phase_lock_i | input | 1 | Oscillator is phase locked to the master; no timeout |
| res_valid_i | input | 1 | One-cycle pulse: a new requester result is present |
| res_master_i | input | 64 | Master time carried by the reply |
| res_link_dly_i | input | 64 | Measured one-way link delay |
| res_t1_i | input | 64 | Local send time of the request |
| res_t4_i | input | 64 | Local receive time of the reply |
| load_lat_i | input | 32 | Fixed compensation for the latency of loading |
| time_o | output | 64 | Current switch time |
| time_valid_o | output | 1 | Current time is trusted |

## Verification
The bound checker watches on every cycle that the time steps by the granularity when nothing is loaded, that a load produces the formula value one edge later, that an invalid clock stays invalid without a load, that root mode forces validity, and that a valid clock under phase lock stays valid. The exact length of the validity window, its restart by a load on the expiry edge, the resumption of the count after phase lock drops, and the behaviour when leaving root mode depend on counted sequences, so only the bench's directed scenarios show them.

// File: rtl/swclk_pkg.sv
package swclk_pkg;

    typedef enum logic [1:0] {
        ST_INVALID  = 2'd0,
        ST_TRACKING = 2'd1,
        ST_PINNED   = 2'd2,
        ST_ROOT     = 2'd3
    } swclk_state_e;

    typedef struct packed {
        logic [63:0] master;
        logic [63:0] link_dly;
        logic [63:0] t1;
        logic [63:0] t4;
    } swclk_result_t;

endpackage

// File: rtl/swclk_load_calc.sv
module swclk_load_calc #(
    parameter int TIME_W = 64,
    parameter int LAT_W  = 32
) (
    input  logic [TIME_W-1:0] master_i,
    input  logic [TIME_W-1:0] link_dly_i,
    input  logic [TIME_W-1:0] t1_i,
    input  logic [TIME_W-1:0] t4_i,
    input  logic [LAT_W-1:0]  lat_i,
    output logic [TIME_W-1:0] value_o
);
    logic [TIME_W-1:0] turnaround;
    logic [TIME_W-1:0] at_port;
    logic [TIME_W-1:0] lat_ext;

    always_comb begin
        // interval the request spent in flight and at the far side
        turnaround = t4_i - t1_i;
        // master time as seen at the local end of the link
        at_port    = master_i - link_dly_i;
        lat_ext    = TIME_W'(lat_i);
        value_o    = at_port + turnaround + lat_ext;
    end
endmodule

// File: rtl/swclk_time_reg.sv
module swclk_time_reg #(
    parameter int TIME_W = 64,
    parameter int GRAN   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TIME_W-1:0] load_val_i,
    output logic [TIME_W-1:0] time_o
);
    localparam logic [TIME_W-1:0] STEP = TIME_W'(GRAN);

    logic [TIME_W-1:0] time_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (load_i) begin
            time_q <= load_val_i;
        end else begin
            time_q <= time_q + STEP;
        end
    end

    assign time_o = time_q;
endmodule

// File: rtl/swclk_window_timer.sv
module swclk_window_timer #(
    parameter int TIMEOUT_CYC = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int CNT_W = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expire_o = run_i && !clear_i && (cnt_q == LAST);
endmodule

// File: rtl/swclk_top.sv
module swclk_top
    import swclk_pkg::*;
#(
    parameter int TIME_W      = 64,
    parameter int LAT_W       = 32,
    parameter int GRAN        = 5,
    parameter int TIMEOUT_CYC = 2_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              root_mode_i,
    input  logic              phase_lock_i,
    input  logic              res_valid_i,
    input  logic [TIME_W-1:0] res_master_i,
    input  logic [TIME_W-1:0] res_link_dly_i,
    input  logic [TIME_W-1:0] res_t1_i,
    input  logic [TIME_W-1:0] res_t4_i,
    input  logic [LAT_W-1:0]  load_lat_i,
    output logic [TIME_W-1:0] time_o,
    output logic              time_valid_o
);
    swclk_state_e state_q, state_d;
    logic              accept;
    logic              expire;
    logic              win_clear;
    logic              win_run;
    logic [TIME_W-1:0] load_val;

    // an upstream result is used only when this switch is not the source
    assign accept = res_valid_i && !root_mode_i;

    swclk_load_calc #(
        .TIME_W (TIME_W),
        .LAT_W  (LAT_W)
    ) u_calc (
        .master_i   (res_master_i),
        .link_dly_i (res_link_dly_i),
        .t1_i       (res_t1_i),
        .t4_i       (res_t4_i),
        .lat_i      (load_lat_i),
        .value_o    (load_val)
    );

    swclk_time_reg #(
        .TIME_W (TIME_W),
        .GRAN   (GRAN)
    ) u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (load_val),
        .time_o     (time_o)
    );

    always_comb begin
        win_clear = accept || (state_q == ST_INVALID) || (state_q == ST_ROOT);
        win_run   = (state_q == ST_TRACKING) && !phase_lock_i;
    end

    swclk_window_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (win_clear),
        .run_i    (win_run),
        .expire_o (expire)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INVALID: begin
                if (root_mode_i)       state_d = ST_ROOT;
                else if (accept)       state_d = phase_lock_i ? ST_PINNED : ST_TRACKING;
            end
            ST_TRACKING: begin
                if (root_mode_i)       state_d = ST_ROOT;
                else if (accept)       state_d = phase_lock_i ? ST_PINNED : ST_TRACKING;
                else if (phase_lock_i) state_d = ST_PINNED;
                else if (expire)       state_d = ST_INVALID;
            end
            ST_PINNED: begin
                if (root_mode_i)       state_d = ST_ROOT;
                else if (!phase_lock_i) state_d = ST_TRACKING;
            end
            ST_ROOT: begin
                if (!root_mode_i) begin
                    if (accept)        state_d = phase_lock_i ? ST_PINNED : ST_TRACKING;
                    else               state_d = ST_INVALID;
                end
            end
            default:                   state_d = ST_INVALID;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INVALID;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_TRACKING, ST_PINNED: time_valid_o = 1'b1;
            ST_ROOT:                time_valid_o = root_mode_i;
            default:                time_valid_o = root_mode_i;
        endcase
    end
endmodule

// File: rtl/swclk_checker.sv
module swclk_checker #(
    parameter int TIME_W = 64,
    parameter int LAT_W  = 32,
    parameter int GRAN   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              root_mode_i,
    input  logic              phase_lock_i,
    input  logic              res_valid_i,
    input  logic [TIME_W-1:0] res_master_i,
    input  logic [TIME_W-1:0] res_link_dly_i,
    input  logic [TIME_W-1:0] res_t1_i,
    input  logic [TIME_W-1:0] res_t4_i,
    input  logic [LAT_W-1:0]  load_lat_i,
    input  logic [TIME_W-1:0] time_o,
    input  logic              time_valid_o
);
    logic              seen_q;
    logic              prev_acc_q;
    logic [TIME_W-1:0] prev_time_q;
    logic [TIME_W-1:0] prev_sum_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            prev_acc_q  <= 1'b0;
            prev_time_q <= '0;
            prev_sum_q  <= '0;
        end else begin
            seen_q      <= 1'b1;
            prev_acc_q  <= res_valid_i && !root_mode_i;
            prev_time_q <= time_o;
            prev_sum_q  <= res_master_i + res_t4_i + TIME_W'(load_lat_i)
                           - res_link_dly_i - res_t1_i;
        end
    end

    a_r2_steady_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !prev_acc_q) |-> (time_o == prev_time_q + TIME_W'(GRAN)));

    a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && prev_acc_q) |-> (time_o == prev_sum_q));

    a_r4_stay_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_valid_o && !res_valid_i && !root_mode_i) |=> (!time_valid_o || root_mode_i));

    a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (time_valid_o && phase_lock_i && !root_mode_i) |=> (time_valid_o || root_mode_i));

    a_r8_root_valid: assert property (@(posedge clk) disable iff (!rst_n)
        root_mode_i |-> time_valid_o);
endmodule

bind swclk_top swclk_checker #(
    .TIME_W (TIME_W),
    .LAT_W  (LAT_W),
    .GRAN   (GRAN)
) u_swclk_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .root_mode_i    (root_mode_i),
    .phase_lock_i   (phase_lock_i),
    .res_valid_i    (res_valid_i),
    .res_master_i   (res_master_i),
    .res_link_dly_i (res_link_dly_i),
    .res_t1_i       (res_t1_i),
    .res_t4_i       (res_t4_i),
    .load_lat_i     (load_lat_i),
    .time_o         (time_o),
    .time_valid_o   (time_valid_o)
);

// File: tb/tb_swclk_top.sv
module tb_swclk_top;
    localparam int TO   = 40;
    localparam int GRAN = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        root_mode, phase_lock, res_valid;
    logic [63:0] res_master, res_link, res_t1, res_t4;
    logic [31:0] load_lat;
    logic [63:0] time_o;
    logic        time_valid;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    swclk_top #(
        .GRAN        (GRAN),
        .TIMEOUT_CYC (TO)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .root_mode_i    (root_mode),
        .phase_lock_i   (phase_lock),
        .res_valid_i    (res_valid),
        .res_master_i   (res_master),
        .res_link_dly_i (res_link),
        .res_t1_i       (res_t1),
        .res_t4_i       (res_t4),
        .load_lat_i     (load_lat),
        .time_o         (time_o),
        .time_valid_o   (time_valid)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Drives one result at a negedge; returns at the next negedge with the
    // expected loaded value checked (R3).
    task automatic do_load(input logic [63:0] m, input logic [63:0] l,
                           input logic [63:0] t1, input logic [63:0] t4,
                           input string req);
        logic [63:0] exp_t;
        exp_t      = m - l + (t4 - t1) + 64'(load_lat);
        res_master = m; res_link = l; res_t1 = t1; res_t4 = t4;
        res_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        res_valid  = 1'b0;
        chk(req, time_o, exp_t);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        cyc(3);
        chk("R1 time in reset", time_o, 64'd0);
        chk("R1 valid in reset", 64'(time_valid), 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_free_run;
        logic [63:0] t0;
        cyc(1);
        t0 = time_o;
        cyc(1);
        chk("R2 step while invalid", time_o, t0 + GRAN);
        cyc(4);
        chk("R2 five steps", time_o, t0 + 5 * GRAN);
        chk("R4 invalid before first load", 64'(time_valid), 64'd0);
    endtask

    task automatic t_load_and_window;
        logic [63:0] t0;
        do_load(64'h1000_0000, 64'd40, 64'd500, 64'd620, "R3 basic load");
        chk("R4 valid after load", 64'(time_valid), 64'd1);
        t0 = time_o;
        cyc(1);
        chk("R2 step after load", time_o, t0 + GRAN);
        cyc(TO - 2);
        chk("R5 valid at last window cycle", 64'(time_valid), 64'd1);
        cyc(1);
        chk("R5 invalid after window", 64'(time_valid), 64'd0);
    endtask

    task automatic t_wrap_load;
        do_load(64'd10, 64'd30, 64'hFFFF_FFFF_FFFF_FFF0, 64'd5, "R3 modulo wrap");
        cyc(TO);
        chk("R5 expired after wrap load", 64'(time_valid), 64'd0);
    endtask

    task automatic t_reload;
        do_load(64'd100, 64'd1, 64'd2, 64'd3, "R3 first of pair");
        cyc(TO - 6);
        do_load(64'd9000, 64'd7, 64'd20, 64'd90, "R3 reload");
        cyc(TO - 1);
        chk("R6 window restarted", 64'(time_valid), 64'd1);
        cyc(1);
        chk("R6 expiry after restart", 64'(time_valid), 64'd0);
    endtask

    task automatic t_load_on_expiry;
        do_load(64'd5000, 64'd3, 64'd4, 64'd8, "R3 before expiry edge");
        cyc(TO - 1);
        do_load(64'd77777, 64'd11, 64'd100, 64'd150, "R3 load on expiry edge");
        chk("R6 load on expiry edge keeps valid", 64'(time_valid), 64'd1);
        cyc(TO - 1);
        chk("R6 full new window", 64'(time_valid), 64'd1);
        cyc(1);
        chk("R6 new window ends", 64'(time_valid), 64'd0);
    endtask

    task automatic t_phase_lock;
        do_load(64'd123456, 64'd6, 64'd1, 64'd9, "R3 before lock");
        phase_lock = 1'b1;
        cyc(3 * TO);
        chk("R7 no timeout while locked", 64'(time_valid), 64'd1);
        phase_lock = 1'b0;
        cyc(TO + 2);
        chk("R7 timeout resumes after unlock", 64'(time_valid), 64'd0);
    endtask

    task automatic t_root;
        logic [63:0] t0;
        root_mode = 1'b1;
        #1;
        chk("R8 valid same cycle", 64'(time_valid), 64'd1);
        t0 = time_o;
        res_master = 64'hDEAD_0000; res_link = 64'd0; res_t1 = 64'd0; res_t4 = 64'd0;
        res_valid  = 1'b1;
        cyc(1);
        res_valid  = 1'b0;
        chk("R8 result ignored", time_o, t0 + GRAN);
        cyc(2 * TO);
        chk("R8 valid stays in root", 64'(time_valid), 64'd1);
        root_mode = 1'b0;
        #1;
        chk("R9 invalid on leaving root", 64'(time_valid), 64'd0);
        cyc(3);
        chk("R9 stays invalid", 64'(time_valid), 64'd0);
        phase_lock = 1'b1;
        do_load(64'd42, 64'd2, 64'd3, 64'd4, "R3 load while locked");
        chk("R9 valid after next load", 64'(time_valid), 64'd1);
        cyc(2 * TO);
        chk("R7 locked from invalid stays valid", 64'(time_valid), 64'd1);
        phase_lock = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; root_mode = 1'b0; phase_lock = 1'b0; res_valid = 1'b0;
        res_master = '0; res_link = '0; res_t1 = '0; res_t4 = '0;
        load_lat = 32'd17;
        @(negedge clk);
        t_reset();
        t_free_run();
        t_load_and_window();
        t_wrap_load();
        t_reload();
        t_load_on_expiry();
        t_phase_lock();
        t_root();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule